// File: doc/BRIEF.md
# Horizontal Phase Shifter and Clamp Generator

This block regenerates a horizontal drive pulse from a one-cycle reference strobe that marks the start of each line. It also places a clamp pulse after the end of that drive pulse. Every delay and width is a fixed fraction of the line period, which is given in clock cycles. The fractions come from integer multiplies by numerators over 1024 and a right shift, so each result is rounded down. The code of 32 places the drive pulse at a nominal latency of floor(P*51/1024) cycles after the strobe. Other codes move it earlier or later by up to that same amount.

All settings are captured on the strobe edge and apply to the whole line that follows: the period, the 6-bit phase code, the clamp delay select and the signal-present flag. The clamp pulse therefore depends only on captured values. If no signal is present, the clamp becomes a fixed pulse whose width is a parameter in clocks. Two drive pins carry the same pulse, and each pin has its own polarity bit.

Top module: `hphase_clamp`

## Requirements
- R1: After reset and until the first reference strobe, both drive pins sit at their inactive level and the clamp output is low. The inactive level is high when the pin's invert bit is 0 and low when it is 1.
- R2: With phase code 32, the drive pulse first shows D0 = floor(P*51/1024) cycles after the strobe edge. Cycle 0 is the first cycle after that edge.
- R3: For any phase code c, the start cycle is D0 + s. Here s = sign(c-32) * floor(|c-32|*P*51/32768). Code 0 gives start 0, the earliest, and code 63 gives the latest start.
- R4: The drive pulse lasts floor(P*76/1024) cycles.
- R5: With the clamp select at 0 and signal present, the clamp starts floor(P*35/1024) cycles after the drive pulse ends. It lasts floor(P*28/1024) cycles.
- R6: With the clamp select at 1 and signal present, the clamp delay is floor(P*17/1024) cycles. The width is unchanged.
- R7: With no signal present, the clamp starts in the first cycle after the drive pulse ends. It lasts NOSIG_W cycles, whatever the clamp select.
- R8: Each drive pin is active low when its invert bit is 0 and active high when it is 1. Both pins show the same pulse timing.
- R9: Changes to the period, phase code, clamp select or signal flag between strobes have no effect on the line in progress. They take effect from the next strobe.
- R10: A strobe arriving mid-line restarts the timing from cycle 0. The clamp is low in the first cycle after any strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| href | input | 1 | One-cycle reference strobe at line start |
| period | input | PW | Measured line period in clocks |
| phase_code | input | 6 | Phase code, 32 is the nominal position |
| clamp_sel | input | 1 | Clamp delay select: 0 long, 1 short |
| sig_ok | input | 1 | Signal present flag |
| inv_a | input | 1 | Polarity bit of hd_a |
| inv_b | input | 1 | Polarity bit of hd_b |
| hd_a | output | 1 | Drive output A |
| hd_b | output | 1 | Drive output B |
| clamp | output | 1 | Clamp pulse, active high |

## Verification
On every cycle, the assertions check three things. The two drive pins agree once their polarity bits are taken into account. The clamp never overlaps the active drive pulse. The clamp is low right after a strobe. Whether a pulse lands on the right cycle with the right length follows from the period, code and select arithmetic. Only the bench scenarios can show that, by measuring start and width against values worked out by hand. The same holds for settings being held for the whole line and for the no-signal fallback.

// File: rtl/hphase_clamp.sv
module hphase_clamp #(
  parameter int PW       = 16,
  parameter int SHIFT_NUM = 51,
  parameter int HDW_NUM  = 76,
  parameter int CDL_NUM  = 35,
  parameter int CDS_NUM  = 17,
  parameter int CW_NUM   = 28,
  parameter int NOSIG_W  = 225
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          href,
  input  logic [PW-1:0] period,
  input  logic [5:0]    phase_code,
  input  logic          clamp_sel,
  input  logic          sig_ok,
  input  logic          inv_a,
  input  logic          inv_b,
  output logic          hd_a,
  output logic          hd_b,
  output logic          clamp
);
  localparam int TW = PW + 1;
  localparam int MW = PW + 16;

  logic [MW-1:0] per_x;
  logic [5:0]    mag_code;
  logic [TW-1:0] d0, mag, w_hd, d_cl, w_cl, n_on, n_off, n_con, n_coff;
  logic [TW-1:0] t_on, t_off, t_con, t_coff, cnt;
  logic          run, hd_act;

  assign per_x    = MW'(period);
  assign mag_code = phase_code[5] ? {1'b0, phase_code[4:0]} : 6'd32 - phase_code;
  assign d0    = TW'((per_x * MW'(SHIFT_NUM)) >> 10);
  assign mag   = TW'((per_x * MW'(SHIFT_NUM) * MW'(mag_code)) >> 15);
  assign w_hd  = TW'((per_x * MW'(HDW_NUM)) >> 10);
  assign d_cl  = clamp_sel ? TW'((per_x * MW'(CDS_NUM)) >> 10)
                           : TW'((per_x * MW'(CDL_NUM)) >> 10);
  assign w_cl  = TW'((per_x * MW'(CW_NUM)) >> 10);

  assign n_on   = phase_code[5] ? d0 + mag : d0 - mag;
  assign n_off  = n_on + w_hd;
  assign n_con  = sig_ok ? n_off + d_cl : n_off;
  assign n_coff = n_con + (sig_ok ? w_cl : TW'(NOSIG_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      cnt    <= '0;
      t_on   <= '0;
      t_off  <= '0;
      t_con  <= '0;
      t_coff <= '0;
    end else if (href) begin
      run    <= 1'b1;
      cnt    <= '0;
      t_on   <= n_on;
      t_off  <= n_off;
      t_con  <= n_con;
      t_coff <= n_coff;
    end else if (cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hd_act = run && cnt >= t_on && cnt < t_off;
  assign clamp  = run && cnt >= t_con && cnt < t_coff;
  assign hd_a   = hd_act ~^ inv_a;
  assign hd_b   = hd_act ~^ inv_b;
endmodule

module hphase_clamp_chk (
  input logic clk,
  input logic rst_n,
  input logic href,
  input logic inv_a,
  input logic inv_b,
  input logic hd_a,
  input logic hd_b,
  input logic clamp,
  input logic hd_act
);
  // R8
  pins_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_a ^ inv_a) == (hd_b ^ inv_b));
  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clamp && hd_a == inv_a));
  // R10
  restart_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    href |=> !clamp);
  // R7
  clamp_after_hd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp) |-> !hd_act);
endmodule

bind hphase_clamp hphase_clamp_chk u_chk (.*);

// File: tb/tb_hphase_clamp.sv
module tb_hphase_clamp;
  logic clk = 0, rst_n = 0, href = 0, clamp_sel = 0, sig_ok = 1, inv_a = 0, inv_b = 0;
  logic [15:0] period = 16'd1000;
  logic [5:0]  phase_code = 6'd32;
  logic hd_a, hd_b, clamp;
  int checks = 0, fails = 0;
  int a_first, a_len, b_first, b_len, c_first, c_len;

  always #2 clk = ~clk;

  hphase_clamp dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) href = 1;
    @(negedge clk) href = 0;
  endtask

  task automatic measure(input int ncyc);
    a_first = -1; a_len = 0; b_first = -1; b_len = 0; c_first = -1; c_len = 0;
    @(negedge clk) href = 1;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk) href = 0;
      if (hd_a == inv_a) begin if (a_first < 0) a_first = k; a_len++; end
      if (hd_b == inv_b) begin if (b_first < 0) b_first = k; b_len++; end
      if (clamp) begin if (c_first < 0) c_first = k; c_len++; end
    end
  endtask

  task automatic t_reset();
    chk(hd_a == 1'b1, "R1 hd_a idle", hd_a, 1);
    chk(hd_b == 1'b1, "R1 hd_b idle", hd_b, 1);
    chk(clamp == 1'b0, "R1 clamp idle", clamp, 0);
  endtask

  task automatic t_nominal();
    phase_code = 32; clamp_sel = 0; sig_ok = 1;
    measure(400);
    chk(a_first == 49, "R2 start code32", a_first, 49);
    chk(a_len == 74, "R4 hd width", a_len, 74);
    chk(c_first == 157, "R5 clamp start sel0", c_first, 157);
    chk(c_len == 27, "R5 clamp width", c_len, 27);
  endtask

  task automatic t_codes();
    phase_code = 0;  measure(400);
    chk(a_first == 0, "R3 code0 start", a_first, 0);
    phase_code = 63; measure(400);
    chk(a_first == 97, "R3 code63 start", a_first, 97);
    phase_code = 40; measure(400);
    chk(a_first == 61, "R3 code40 start", a_first, 61);
    phase_code = 20; measure(400);
    chk(a_first == 31, "R3 code20 start", a_first, 31);
    chk(a_len == 74, "R4 width code20", a_len, 74);
    phase_code = 32;
  endtask

  task automatic t_short();
    clamp_sel = 1; measure(400);
    chk(c_first == 139, "R6 clamp start sel1", c_first, 139);
    chk(c_len == 27, "R6 clamp width sel1", c_len, 27);
    clamp_sel = 0;
  endtask

  task automatic t_nosig();
    sig_ok = 0; clamp_sel = 1; measure(400);
    chk(c_first == 123, "R7 nosig clamp start", c_first, 123);
    chk(c_len == 225, "R7 nosig clamp width", c_len, 225);
    sig_ok = 1; clamp_sel = 0;
  endtask

  task automatic t_invert();
    inv_a = 1; inv_b = 0; measure(60);
    chk(a_first == 49 && b_first == 49, "R8 both pins start", a_first, 49);
    @(negedge clk);
    chk(hd_a == 1'b1 && hd_b == 1'b0, "R8 active levels", {hd_a, hd_b}, 2'b10);
    inv_a = 0; inv_b = 1;
    @(negedge clk);
    chk(hd_a == 1'b0 && hd_b == 1'b1, "R8 swapped levels", {hd_a, hd_b}, 2'b01);
    inv_b = 0;
  endtask

  task automatic t_latch();
    a_first = -1; c_first = -1;
    @(negedge clk) href = 1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk) href = 0;
      if (k == 10) begin phase_code = 0; clamp_sel = 1; sig_ok = 0; period = 16'd2000; end
      if (hd_a == inv_a && a_first < 0) a_first = k;
      if (clamp && c_first < 0) c_first = k;
    end
    chk(a_first == 49, "R9 held code", a_first, 49);
    chk(c_first == 157, "R9 held clamp", c_first, 157);
    period = 16'd1000; sig_ok = 1; clamp_sel = 0; measure(100);
    chk(a_first == 0, "R9 new code next line", a_first, 0);
    phase_code = 32;
  endtask

  task automatic t_restart();
    strobe();
    repeat (60) @(negedge clk);
    measure(400);
    chk(a_first == 49, "R10 restart start", a_first, 49);
    chk(c_first == 157, "R10 restart clamp", c_first, 157);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_nominal();
    t_codes();
    t_short();
    t_nosig();
    t_invert();
    t_latch();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule